// File: doc/BRIEF.md
# DRAM Request Scheduler with Write Drain

The scheduler keeps pending DRAM requests in two arrival-ordered queues, one for reads and one for writes. Each request names a bank and a row. In every cycle the block offers one request to a downstream command sequencer. The request leaves its queue in the cycle the sequencer raises its ready input. A table holds the open row of each bank. It is written when a request issues and cleared when the sequencer reports a precharge. That table drives an optional row-hit-first ordering.

Reads normally win. Writes collect until the write queue reaches a fill level set as a percentage of its depth. The block then serves only writes until the write queue is empty, so it does not swap direction on every request. The ordering policy and the page policy are runtime inputs.

Top module: `dram_req_sched`

## Requirements
- R1: After reset `iss_valid_o` is 0, `enq_ready_o` is 1 for both request kinds, and `draining_o` is 0.
- R2: Each queue holds up to its depth (32 by default). `enq_ready_o` is 0 when the queue picked by `enq_write_i` (1 = write, 0 = read) is full, and an offered request is then not taken.
- R3: With `policy_i` = 0 (arrival order), the request issued from a queue is the oldest in that queue.
- R4: With `policy_i` = 1 (row hit first), the issued request is the oldest one in the selected queue whose row equals the open row of its bank. If the queue has no such request, the oldest one issues.
- R5: With `close_page_i` = 0, an issued request records its row as open for its bank. A precharge report (`pre_valid_i`, `pre_bank_i`) marks that bank as having no open row. When both occur for the same bank in one cycle, the issue wins.
- R6: With `close_page_i` = 1, an issued request leaves its bank with no open row.
- R7: `iss_hit_o` is 1 exactly when the offered request's row equals the recorded open row of its bank.
- R8: `draining_o` rises in the first cycle the write queue holds at least floor(WQ_DEPTH*DRAIN_PCT/100) entries (22 by default). While `draining_o` is high, only writes are offered.
- R9: Once set, `draining_o` stays high until the write queue is empty.
- R10: While not draining, a read is offered whenever the read queue is not empty. A write is offered only when the read queue is empty.
- R11: A request leaves its queue only in a cycle where `iss_valid_o` and `iss_ready_i` are both high. `iss_valid_o` is high whenever either queue holds a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | 0 = arrival order, 1 = row hit first |
| close_page_i | input | 1 | 1 = no row is kept open after an issue |
| enq_valid_i | input | 1 | Request offered |
| enq_ready_o | output | 1 | Target queue has room |
| enq_write_i | input | 1 | 1 = write, 0 = read |
| enq_bank_i | input | BANK_W | Bank index |
| enq_row_i | input | ROW_W | Row address |
| iss_valid_o | output | 1 | A request is offered downstream |
| iss_ready_i | input | 1 | Sequencer accepts the offered request |
| iss_write_o | output | 1 | Offered request is a write |
| iss_bank_o | output | BANK_W | Offered bank |
| iss_row_o | output | ROW_W | Offered row |
| iss_hit_o | output | 1 | Offered request hits its bank's open row |
| pre_valid_i | input | 1 | Precharge report |
| pre_bank_i | input | BANK_W | Bank that was precharged |
| draining_o | output | 1 | Write drain mode active |

## Verification
A corrupted queue slot or count shows at the issue port in the cycle that slot becomes the selected candidate. It appears as a wrong bank or row, a request issued twice, or a request lost. A stale open-row entry shows at once on `iss_hit_o`, and under row-hit-first ordering as an out-of-order issue. A mistake in the drain state shows at the first cycle the write count crosses the fill level or reaches zero: `draining_o` flips in the wrong cycle, or reads are offered while writes are still pending. The bench compares every output in every cycle against a queue model. Each such fault is therefore reported in the cycle it first reaches a port.

// File: rtl/dsch_pkg.sv
package dsch_pkg;
  typedef enum logic {
    POL_ARRIVAL = 1'b0,
    POL_ROW_HIT = 1'b1
  } policy_e;

  function automatic int drain_level(input int depth, input int pct);
    int lvl;
    lvl = (depth * pct) / 100;
    if (lvl < 1) lvl = 1;
    if (lvl > depth) lvl = depth;
    return lvl;
  endfunction
endpackage

// File: rtl/req_queue.sv
module req_queue #(
  parameter int DEPTH = 32,
  parameter int W     = 18,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      enq_i,
  input  logic [W-1:0]              enq_data_i,
  input  logic                      deq_i,
  input  logic [IDX_W-1:0]          deq_idx_i,
  output logic [DEPTH-1:0][W-1:0]   data_o,
  output logic [CNT_W-1:0]          cnt_o
);
  logic [DEPTH-1:0][W-1:0] mem_q, mem_d;
  logic [DEPTH:0][W-1:0]   ext;
  logic [CNT_W-1:0]        cnt_q, cnt_mid;

  always_comb begin
    ext = '0;
    for (int i = 0; i < DEPTH; i++) ext[i] = mem_q[i];
    cnt_mid = cnt_q - CNT_W'(deq_i);
    for (int i = 0; i < DEPTH; i++) begin
      // close the gap left by a removed slot, keeping age order
      if (deq_i && IDX_W'(i) >= deq_idx_i) mem_d[i] = ext[i+1];
      else                                 mem_d[i] = mem_q[i];
      if (enq_i && CNT_W'(i) == cnt_mid)   mem_d[i] = enq_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_mid + CNT_W'(enq_i);
    end
  end

  assign data_o = mem_q;
  assign cnt_o  = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_i |-> (cnt_q < CNT_W'(DEPTH) || deq_i)); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_i |-> (CNT_W'(deq_idx_i) < cnt_q)); // R11
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] live_i,
  input  logic [DEPTH-1:0] hit_i,
  input  logic             row_first_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [DEPTH-1:0] cand;

  always_comb begin
    cand = live_i & hit_i;
    if (!row_first_i || cand == '0) cand = live_i;
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/open_row_tbl.sv
module open_row_tbl #(
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 14,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            upd_i,
  input  logic [BANK_W-1:0]               upd_bank_i,
  input  logic [ROW_W-1:0]                upd_row_i,
  input  logic                            upd_keep_i,
  input  logic                            clr_i,
  input  logic [BANK_W-1:0]               clr_bank_i,
  output logic [NUM_BANKS-1:0]            vld_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] row_o
);
  logic [NUM_BANKS-1:0]            vld_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      row_q <= '0;
    end else begin
      if (clr_i) vld_q[clr_bank_i] <= 1'b0;
      if (upd_i) begin  // issue overrides a same-cycle precharge
        vld_q[upd_bank_i] <= upd_keep_i;
        row_q[upd_bank_i] <= upd_row_i;
      end
    end
  end

  assign vld_o = vld_q;
  assign row_o = row_q;

  AST_CLOSE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !upd_keep_i) |=> !vld_q[$past(upd_bank_i)]); // R6
  AST_PRE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(upd_i && upd_bank_i == clr_bank_i)) |=> !vld_q[$past(clr_bank_i)]); // R5
  AST_OPEN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_keep_i) |=> (vld_q[$past(upd_bank_i)] && row_q[$past(upd_bank_i)] == $past(upd_row_i))); // R5
endmodule

// File: rtl/dram_req_sched.sv
module dram_req_sched
  import dsch_pkg::*;
#(
  parameter int RQ_DEPTH  = 32,
  parameter int WQ_DEPTH  = 32,
  parameter int NUM_BANKS = 16,
  parameter int ROW_W     = 14,
  parameter int DRAIN_PCT = 70,
  localparam int BANK_W  = $clog2(NUM_BANKS),
  localparam int ENT_W   = BANK_W + ROW_W,
  localparam int RIDX_W  = $clog2(RQ_DEPTH),
  localparam int WIDX_W  = $clog2(WQ_DEPTH),
  localparam int RCNT_W  = $clog2(RQ_DEPTH + 1),
  localparam int WCNT_W  = $clog2(WQ_DEPTH + 1),
  localparam int DRAIN_LVL = drain_level(WQ_DEPTH, DRAIN_PCT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              policy_i,
  input  logic              close_page_i,
  input  logic              enq_valid_i,
  output logic              enq_ready_o,
  input  logic              enq_write_i,
  input  logic [BANK_W-1:0] enq_bank_i,
  input  logic [ROW_W-1:0]  enq_row_i,
  output logic              iss_valid_o,
  input  logic              iss_ready_i,
  output logic              iss_write_o,
  output logic [BANK_W-1:0] iss_bank_o,
  output logic [ROW_W-1:0]  iss_row_o,
  output logic              iss_hit_o,
  input  logic              pre_valid_i,
  input  logic [BANK_W-1:0] pre_bank_i,
  output logic              draining_o
);
  logic [RQ_DEPTH-1:0][ENT_W-1:0] rq_data;
  logic [WQ_DEPTH-1:0][ENT_W-1:0] wq_data;
  logic [RCNT_W-1:0]              rq_cnt;
  logic [WCNT_W-1:0]              wq_cnt;
  logic [RQ_DEPTH-1:0]            rq_live, rq_hit;
  logic [WQ_DEPTH-1:0]            wq_live, wq_hit;
  logic [RIDX_W-1:0]              rq_idx;
  logic [WIDX_W-1:0]              wq_idx;
  logic [NUM_BANKS-1:0]           open_vld;
  logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
  logic rq_full, wq_full, rq_enq, wq_enq, sel_wr, fire, drain_q, drain_act;
  logic [ENT_W-1:0] sel_ent;

  assign rq_full = (rq_cnt == RCNT_W'(RQ_DEPTH));
  assign wq_full = (wq_cnt == WCNT_W'(WQ_DEPTH));
  assign enq_ready_o = enq_write_i ? !wq_full : !rq_full;
  assign rq_enq = enq_valid_i && !enq_write_i && !rq_full;
  assign wq_enq = enq_valid_i &&  enq_write_i && !wq_full;

  // hit flags per queue slot against the open-row table
  for (genvar i = 0; i < RQ_DEPTH; i++) begin : g_rhit
    logic [BANK_W-1:0] b;
    assign b = rq_data[i][ENT_W-1:ROW_W];
    assign rq_live[i] = RCNT_W'(i) < rq_cnt;
    assign rq_hit[i]  = open_vld[b] && (open_row[b] == rq_data[i][ROW_W-1:0]);
  end
  for (genvar i = 0; i < WQ_DEPTH; i++) begin : g_whit
    logic [BANK_W-1:0] b;
    assign b = wq_data[i][ENT_W-1:ROW_W];
    assign wq_live[i] = WCNT_W'(i) < wq_cnt;
    assign wq_hit[i]  = open_vld[b] && (open_row[b] == wq_data[i][ROW_W-1:0]);
  end

  sched_pick #(.DEPTH(RQ_DEPTH)) u_rpick (
    .live_i(rq_live), .hit_i(rq_hit), .row_first_i(policy_i == POL_ROW_HIT), .idx_o(rq_idx));
  sched_pick #(.DEPTH(WQ_DEPTH)) u_wpick (
    .live_i(wq_live), .hit_i(wq_hit), .row_first_i(policy_i == POL_ROW_HIT), .idx_o(wq_idx));

  // drain hysteresis: enter at the fill level, leave only when empty
  assign drain_act = (wq_cnt >= WCNT_W'(DRAIN_LVL)) || (drain_q && wq_cnt != '0);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drain_q <= 1'b0;
    else         drain_q <= drain_act;
  end

  assign sel_wr      = drain_act || (rq_cnt == '0);
  assign iss_valid_o = sel_wr ? (wq_cnt != '0) : 1'b1;
  assign sel_ent     = sel_wr ? wq_data[wq_idx] : rq_data[rq_idx];
  assign iss_write_o = sel_wr;
  assign iss_bank_o  = sel_ent[ENT_W-1:ROW_W];
  assign iss_row_o   = sel_ent[ROW_W-1:0];
  assign iss_hit_o   = iss_valid_o && (sel_wr ? wq_hit[wq_idx] : rq_hit[rq_idx]);
  assign draining_o  = drain_act;
  assign fire        = iss_valid_o && iss_ready_i;

  req_queue #(.DEPTH(RQ_DEPTH), .W(ENT_W)) u_rq (
    .clk_i, .rst_ni,
    .enq_i(rq_enq), .enq_data_i({enq_bank_i, enq_row_i}),
    .deq_i(fire && !sel_wr), .deq_idx_i(rq_idx),
    .data_o(rq_data), .cnt_o(rq_cnt));

  req_queue #(.DEPTH(WQ_DEPTH), .W(ENT_W)) u_wq (
    .clk_i, .rst_ni,
    .enq_i(wq_enq), .enq_data_i({enq_bank_i, enq_row_i}),
    .deq_i(fire && sel_wr), .deq_idx_i(wq_idx),
    .data_o(wq_data), .cnt_o(wq_cnt));

  open_row_tbl #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_tbl (
    .clk_i, .rst_ni,
    .upd_i(fire), .upd_bank_i(iss_bank_o), .upd_row_i(iss_row_o),
    .upd_keep_i(!close_page_i),
    .clr_i(pre_valid_i), .clr_bank_i(pre_bank_i),
    .vld_o(open_vld), .row_o(open_row));

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    draining_o |=> (draining_o || wq_cnt == '0)); // R9
  AST_DRAIN_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (draining_o && iss_valid_o) |-> iss_write_o); // R8
  AST_READ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!draining_o && rq_cnt != '0) |-> (iss_valid_o && !iss_write_o)); // R10
  AST_OFFER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rq_cnt != '0 || wq_cnt != '0) |-> iss_valid_o); // R11
endmodule

// File: tb/tb_dram_req_sched.sv
module tb_dram_req_sched;
  localparam int DEPTH = 32;
  localparam int LVL   = 22;
  localparam int NB    = 16;

  typedef struct { int bank; int row; } ent_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic policy = 1'b0, close_pg = 1'b0;
  logic enq_valid = 1'b0, enq_write = 1'b0, iss_ready = 1'b0, pre_valid = 1'b0;
  logic [3:0] enq_bank = '0, pre_bank = '0;
  logic [13:0] enq_row = '0;
  logic enq_ready, iss_valid, iss_write, iss_hit, draining;
  logic [3:0] iss_bank;
  logic [13:0] iss_row;

  int checks = 0, errors = 0;
  ent_t mrq[$], mwq[$];
  bit   ovld[NB];
  int   orow[NB];
  bit   mdrain = 1'b0;

  always #4 clk = ~clk;

  dram_req_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .close_page_i(close_pg),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_write_i(enq_write),
    .enq_bank_i(enq_bank), .enq_row_i(enq_row),
    .iss_valid_o(iss_valid), .iss_ready_i(iss_ready), .iss_write_o(iss_write),
    .iss_bank_o(iss_bank), .iss_row_o(iss_row), .iss_hit_o(iss_hit),
    .pre_valid_i(pre_valid), .pre_bank_i(pre_bank), .draining_o(draining));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_hit(ent_t e);
    return ovld[e.bank] && orow[e.bank] == e.row;
  endfunction

  function automatic int pick(ref ent_t q[$]);
    if (policy) begin
      for (int i = 0; i < q.size(); i++) if (is_hit(q[i])) return i;
    end
    return 0;
  endfunction

  // one cycle: drive, compare all outputs to the model, advance the model
  task automatic step(bit v, bit w, int b, int r, bit rdy, bit pv, int pb);
    bit   dr, sw, ev, er, fire, acc;
    int   idx;
    ent_t e, n;
    @(negedge clk);
    enq_valid = v; enq_write = w; enq_bank = 4'(b); enq_row = 14'(r);
    iss_ready = rdy; pre_valid = pv; pre_bank = 4'(pb);
    #1;
    dr = (mwq.size() >= LVL) || (mdrain && mwq.size() != 0);
    sw = dr || mrq.size() == 0;
    ev = sw ? (mwq.size() != 0) : 1'b1;
    er = w ? (mwq.size() < DEPTH) : (mrq.size() < DEPTH);
    chk("R8/R9 draining", int'(draining), int'(dr));
    chk("R2 enq_ready", int'(enq_ready), int'(er));
    chk("R11 iss_valid", int'(iss_valid), int'(ev));
    idx = 0;
    if (ev) begin
      idx = sw ? pick(mwq) : pick(mrq);
      e   = sw ? mwq[idx] : mrq[idx];
      chk("R10 iss_write", int'(iss_write), int'(sw));
      chk(policy ? "R4 iss_bank" : "R3 iss_bank", int'(iss_bank), e.bank);
      chk(policy ? "R4 iss_row" : "R3 iss_row", int'(iss_row), e.row);
      chk("R7 iss_hit", int'(iss_hit), int'(is_hit(e)));
    end
    fire = ev && rdy;
    acc  = v && er;
    @(posedge clk);
    mdrain = dr;
    if (fire) begin
      if (sw) mwq.delete(idx); else mrq.delete(idx);
    end
    n.bank = b; n.row = r;
    if (acc) begin
      if (w) mwq.push_back(n); else mrq.push_back(n);
    end
    if (pv) ovld[pb] = 1'b0;
    if (fire) begin
      ovld[e.bank] = !close_pg;  // R5 R6
      orow[e.bank] = e.row;
    end
  endtask

  task automatic rand_phase(int n, int p_enq, int p_wr, int p_rdy, int p_pre);
    for (int k = 0; k < n; k++)
      step(($urandom % 100) < p_enq, ($urandom % 100) < p_wr, $urandom % 4,
           $urandom % 4, ($urandom % 100) < p_rdy, ($urandom % 100) < p_pre, $urandom % 4);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NB; i++) begin ovld[i] = 0; orow[i] = 0; end
    #20;
    // R1 reset state
    chk("R1 iss_valid", int'(iss_valid), 0);
    chk("R1 enq_ready", int'(enq_ready), 1);
    chk("R1 draining", int'(draining), 0);
    @(negedge clk); rst_n = 1'b1;

    // R8 directed: fill to one below the level, then cross it
    for (int k = 0; k < LVL - 1; k++) step(1, 1, k % 4, k % 3, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R8 below level", int'(draining), 0);
    step(1, 1, 1, 1, 0, 0, 0);
    step(1, 0, 2, 2, 0, 0, 0);
    chk("R8 at level", int'(draining), 1);
    // R2 directed: fill write queue
    for (int k = 0; k < DEPTH; k++) step(1, 1, 3, k % 4, 0, 0, 0);
    enq_write = 1'b1; #1;
    chk("R2 full write queue", int'(enq_ready), 0);
    // R9: drain until empty while a read waits
    while (mwq.size() != 0) step(0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R9 drain ended", int'(draining), 0);
    while (mrq.size() != 0 || mwq.size() != 0) step(0, 0, 0, 0, 1, 0, 0);

    // R5 directed: precharge and issue to same bank in one cycle, issue wins
    policy = 1'b1;
    step(1, 0, 2, 5, 0, 0, 0);
    step(1, 0, 2, 5, 1, 1, 2);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5 issue beats precharge", int'(iss_hit), 1);
    step(0, 0, 0, 0, 0, 1, 2);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R5 precharge clears", int'(iss_hit), 0);
    step(0, 0, 0, 0, 1, 0, 0);

    policy = 1'b0; close_pg = 1'b0;
    rand_phase(3000, 60, 40, 50, 5);   // R3
    rand_phase(1500, 70, 60, 25, 5);
    policy = 1'b1;
    rand_phase(3000, 60, 40, 50, 5);   // R4
    rand_phase(1500, 70, 60, 25, 10);
    close_pg = 1'b1;
    rand_phase(2000, 60, 50, 45, 5);   // R6
    policy = 1'b0;
    rand_phase(1000, 60, 50, 45, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule